// File: doc/BRIEF.md
# Host Bus Slave DMA Redirector

This block sits on a simple synchronous host register bus, in front of a bank of per-queue receive and transmit data registers. In normal operation, bus addresses are decoded. Address zero selects a control register. Addresses with the top bit set select a data register directly through the endpoint port. All other addresses read as zero and ignore writes.

The host writes the control register to enter a slave DMA mode. The write sets one mode flag and a target data-register index. From then on, accesses of the matching direction go to the target register whatever address the host drives. After each steered access the word part of the target index steps forward. It wraps inside the window of the selected queue, so it never moves into another queue.

Read mode ends on any host write cycle. That write is used only as a terminator. Write mode ends when the host writes the control register with the write flag cleared. A busy output is high while either mode is active, so surrounding logic can hold off interrupt service routines.

Top module: `dma_redirect`

## Requirements
- R1: After reset, `dma_busy` is 0 and a read of address 0 returns 0.
- R2: With no mode active, address 0 accesses the control register. An address with bit AW-1 set reaches the endpoint at index `h_addr[IW-1:0]`. Any other address reads 0, and a write to it changes nothing. Index layout is {direction (1 = transmit), queue, word}. The control word holds the read flag in bit 0, the write flag in bit 1 and the target index at bit 8 upward.
- R3: A control-register write with bits 1 and 0 both set is ignored. The modes and the target index stay as they were.
- R4: In read mode, every host read takes its data from the endpoint at the target index, whatever the bus address.
- R5: After each steered access, the word field of the target index increments modulo WIN. The direction and queue fields do not change.
- R6: In read mode, any host write cycle clears read mode. It makes no endpoint access and changes no other state.
- R7: In write mode, every host write to a nonzero address goes to the endpoint at the target index and advances it. Reads are decoded normally.
- R8: In write mode, a control-register write with bit 1 clear ends write mode and loads the written fields.
- R9: `dma_busy` is 1 exactly while read mode or write mode is active. The two modes are never active together.
- R10: Read data appears on `h_rdata` in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access strobe |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Registered host read data |
| ep_valid | output | 1 | Endpoint access strobe |
| ep_write | output | 1 | Endpoint write |
| ep_index | output | IW | Endpoint data-register index |
| ep_wdata | output | DW | Endpoint write data |
| ep_rdata | input | DW | Endpoint read data (combinational) |
| dma_busy | output | 1 | A slave DMA mode is active |

## Verification
Directed sequences cover several cases. In read mode, drains use scattered bus addresses, which shows whether the bus address is really ignored. A drain that runs past the last word of a window shows whether the index wraps or carries into the queue field. Writes in read mode aimed at data addresses show whether the terminator leaks through as a store. Random traffic mixes control writes (including both flags set), reads and writes to all address classes, and compares every read and the busy flag against a bench model of the control state and the endpoint memory. This separates normal decoding from steering in each mode.

// File: rtl/dma_redirect.sv
module dma_redirect #(
  parameter int DW = 16,
  parameter int NQ = 4,
  parameter int WIN = 8,
  localparam int QW = $clog2(NQ),
  localparam int WW = $clog2(WIN),
  localparam int IW = 1 + QW + WW,
  localparam int AW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  input  logic          h_write,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          ep_valid,
  output logic          ep_write,
  output logic [IW-1:0] ep_index,
  output logic [DW-1:0] ep_wdata,
  input  logic [DW-1:0] ep_rdata,
  output logic          dma_busy
);

  logic          rd_mode, wr_mode;
  logic [IW-1:0] tgt;
  logic [DW-1:0] ctrl_val;

  wire hit_ctrl = (h_addr == '0);
  wire hit_data = h_addr[AW-1];
  wire rd_cyc   = h_valid & ~h_write;
  wire wr_cyc   = h_valid & h_write;
  wire steer_rd = rd_mode & rd_cyc;
  wire steer_wr = wr_mode & wr_cyc & ~hit_ctrl;
  wire kill_rd  = rd_mode & wr_cyc;
  wire norm     = h_valid & ~rd_mode & ~steer_wr;
  wire ctrl_wr  = norm & h_write & hit_ctrl & ~(h_wdata[0] & h_wdata[1]);
  wire steer    = steer_rd | steer_wr;

  wire [IW-1:0] tgt_next = {tgt[IW-1:WW], tgt[WW-1:0] + 1'b1};

  assign ep_valid = steer | (norm & hit_data);
  assign ep_write = ep_valid & h_write;
  assign ep_index = steer ? tgt : h_addr[IW-1:0];
  assign ep_wdata = h_wdata;
  assign dma_busy = rd_mode | wr_mode;

  always_comb begin
    ctrl_val = '0;
    ctrl_val[0] = rd_mode;
    ctrl_val[1] = wr_mode;
    ctrl_val[8 +: IW] = tgt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mode <= 1'b0;
      wr_mode <= 1'b0;
      tgt     <= '0;
    end else if (kill_rd) begin
      rd_mode <= 1'b0;
    end else if (ctrl_wr) begin
      rd_mode <= h_wdata[0];
      wr_mode <= h_wdata[1];
      tgt     <= h_wdata[8 +: IW];
    end else if (steer) begin
      tgt <= tgt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      h_rdata <= '0;
    else if (rd_cyc) begin
      if (steer_rd || hit_data) h_rdata <= ep_rdata;
      else if (hit_ctrl)        h_rdata <= ctrl_val;
      else                      h_rdata <= '0;
    end
  end

endmodule

module dma_redirect_chk #(
  parameter int DW = 16,
  parameter int IW = 6,
  parameter int WW = 3,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_valid,
  input logic          h_write,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_wdata,
  input logic          ep_valid,
  input logic          ep_write,
  input logic [IW-1:0] ep_index,
  input logic          dma_busy,
  input logic          rd_mode,
  input logic          wr_mode,
  input logic [IW-1:0] tgt
);

  a_r9_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_mode, wr_mode}));

  a_r2_no_spurious_ep: assert property (@(posedge clk) disable iff (!rst_n)
    !h_valid |-> !ep_valid);

  a_r4_read_steered: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && h_valid && !h_write) |-> (ep_valid && !ep_write && ep_index == tgt));

  a_r5_stays_in_queue: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_mode || wr_mode) && h_valid && h_addr != '0) |=> tgt[IW-1:WW] == $past(tgt[IW-1:WW]));

  a_r6_write_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && h_valid && h_write) |-> !ep_valid ##1 !dma_busy);

  a_r3_both_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_mode && h_valid && h_write && h_addr == '0 && h_wdata[1:0] == 2'b11)
      |=> (rd_mode == $past(rd_mode) && wr_mode == $past(wr_mode) && tgt == $past(tgt)));

  a_r7_write_steered: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && h_valid && h_write && h_addr != '0) |-> (ep_valid && ep_write && ep_index == tgt));

endmodule

bind dma_redirect dma_redirect_chk #(.DW(DW), .IW(IW), .WW(WW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr),
  .h_wdata(h_wdata), .ep_valid(ep_valid), .ep_write(ep_write), .ep_index(ep_index),
  .dma_busy(dma_busy), .rd_mode(rd_mode), .wr_mode(wr_mode), .tgt(tgt)
);

// File: tb/dma_redirect_tb.sv
module dma_redirect_tb_top;
  localparam int DW = 16, NQ = 4, WIN = 8;
  localparam int WW = $clog2(WIN), IW = 1 + $clog2(NQ) + WW, AW = IW + 1;
  localparam int NR = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic h_valid = 0, h_write = 0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [DW-1:0] h_rdata, ep_wdata, ep_rdata;
  logic ep_valid, ep_write, dma_busy;
  logic [IW-1:0] ep_index;

  always #10 clk = ~clk;

  dma_redirect #(.DW(DW), .NQ(NQ), .WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .ep_valid(ep_valid), .ep_write(ep_write),
    .ep_index(ep_index), .ep_wdata(ep_wdata), .ep_rdata(ep_rdata), .dma_busy(dma_busy));

  logic [DW-1:0] mem [NR];
  assign ep_rdata = mem[ep_index];
  always @(posedge clk) if (ep_valid && ep_write) mem[ep_index] <= ep_wdata;

  logic [DW-1:0] exp_mem [NR];
  logic m_rd, m_wr;
  logic [IW-1:0] m_idx;
  int errors = 0, checks = 0;

  function automatic logic [DW-1:0] seed_val(int i);
    return DW'(16'hA000 + i * 16'h0107);
  endfunction

  function automatic logic [IW-1:0] inc(logic [IW-1:0] x);
    return {x[IW-1:WW], x[WW-1:0] + 1'b1};
  endfunction

  function automatic logic [DW-1:0] ctrl_word(logic rd, logic wr, logic [IW-1:0] idx);
    logic [DW-1:0] v = '0;
    v[0] = rd; v[1] = wr; v[8 +: IW] = idx;
    return v;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(logic wr, logic [AW-1:0] addr, logic [DW-1:0] data);
    logic [DW-1:0] exp = '0;
    string tag;
    tag = m_rd ? (wr ? "R6" : "R4") : (m_wr && wr && addr != 0) ? "R7" :
          (addr == 0 && wr && data[1:0] == 2'b11) ? "R3" : (m_wr && addr == 0) ? "R8" : "R2";
    if (m_rd) begin
      if (wr) m_rd = 0;
      else begin exp = exp_mem[m_idx]; m_idx = inc(m_idx); end
    end else if (m_wr && wr && addr != 0) begin
      exp_mem[m_idx] = data; m_idx = inc(m_idx);
    end else if (addr == 0) begin
      if (wr) begin
        if (data[1:0] != 2'b11) begin m_rd = data[0]; m_wr = data[1]; m_idx = data[8 +: IW]; end
      end else exp = ctrl_word(m_rd, m_wr, m_idx);
    end else if (addr[AW-1]) begin
      if (wr) exp_mem[addr[IW-1:0]] = data;
      else exp = exp_mem[addr[IW-1:0]];
    end
    h_valid = 1; h_write = wr; h_addr = addr; h_wdata = data;
    @(negedge clk);
    h_valid = 0;
    if (!wr) check({tag, " R10 rdata"}, h_rdata, exp);
    check("R9 busy", DW'(dma_busy), DW'(m_rd | m_wr));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NR; i++) begin mem[i] = seed_val(i); exp_mem[i] = seed_val(i); end
    m_rd = 0; m_wr = 0; m_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 busy", DW'(dma_busy), '0);
    op(0, 0, 0);                                     // R1 control reads 0
    op(1, AW'(64 + 5), 16'h1234);                    // R2 direct data write
    op(0, AW'(64 + 5), 0);                           // R2 read back
    op(1, AW'(16), 16'hFFFF);                        // R2 unmapped write
    op(0, AW'(16), 0);                               // R2 unmapped reads 0
    op(0, 0, 0);
    op(1, 0, ctrl_word(1, 1, 6'd9));                 // R3 both bits ignored
    op(0, 0, 0);
    op(1, 0, ctrl_word(1, 0, IW'(2 * WIN + 6)));     // R4 read mode, q2 rx word 6
    op(0, AW'(77), 0);
    op(0, AW'(0), 0);
    op(0, AW'(3), 0);                                // R5 wrap to word 0
    op(1, AW'(64 + 21), 16'hDEAD);                   // R6 terminator
    op(0, 0, 0);
    op(0, AW'(64 + 21), 0);                          // R6 no store
    op(1, 0, ctrl_word(0, 1, IW'(32 + WIN + 7)));    // R7 write mode, q1 tx word 7
    op(1, AW'(9), 16'h0A0A);
    op(1, AW'(64), 16'h0B0B);                        // R5 wrap in tx window
    op(0, 0, 0);                                     // R7 reads decoded normally
    op(1, 0, ctrl_word(0, 0, IW'(3)));               // R8 end write mode
    op(0, AW'(32 + WIN + 7 + 64), 0);
    op(0, AW'(32 + WIN + 64), 0);
    for (int n = 0; n < 1500; n++) begin
      int k = $urandom_range(0, 9);
      logic [AW-1:0] a = (k < 2) ? '0 : AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      if (k < 2) begin
        d[1:0] = 2'($urandom_range(0, 3));
        d[8 +: IW] = IW'($urandom);
      end
      op(k[0], a, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule